// File: doc/BRIEF.md
# Four-Channel Converter Burst Reader

This block is an SPI master that collects one set of simultaneous results from a four-channel delta-sigma converter each time the converter announces a new conversion. The converter's active-low ready line goes through a two-flop synchronizer, and its falling edge is detected. On that edge the reader drops chip select and shifts out a single read control byte. It then keeps the clock running, without a chip-select toggle, until all four channel results have come back. The results appear together on one wide frame output with a one-cycle valid strobe.

Each result is 16 bits wide by default, or 24 bits when the wide input is high at the start of a burst. The serial clock runs at a parameterised fraction of the system clock. Chip select is held after the last falling clock edge for one full half period, so the final bit has left the line before the device is released. A ready edge that arrives while a burst is still running is dropped, and a sticky flag records the loss.

Top module: `adc_burst_reader`

## Requirements
- R1: The reader synchronizes a falling edge on `drdy_n` through two flops. When the reader is idle, `cs_n` goes low on the third rising clock edge after the input falls.
- R2: The first eight SCLK cycles of a burst send the control byte on `mosi`, MSB first. Bits 7:6 hold the device address `01`, bits 5:1 hold `START_REG` (default 0) and bit 0 is 1 (read), so the default byte is 0x41.
- R3: SCLK idles low and is low whenever `cs_n` is high. `mosi` changes only while SCLK is low. `miso` is sampled at each SCLK rising edge.
- R4: One burst has exactly 8 + 4×16 = 72 SCLK rising edges (narrow) or 8 + 4×24 = 104 (wide), all under one low period of `cs_n`.
- R5: `wide_sel` is latched when a burst starts. Changing it during a burst does not change that burst's length or frame.
- R6: After the control byte, results arrive MSB first, channel 0 first. Channel i appears on `frame_data[24*i+23 : 24*i]`. Narrow results are zero-extended in that slot.
- R7: Each SCLK half period lasts `HALF_DIV` system clocks. `cs_n` rises exactly `HALF_DIV` clocks after the last SCLK falling edge.
- R8: `frame_valid` is a one-cycle pulse one clock after `cs_n` rises. `frame_data` changes only together with that pulse.
- R9: `miso` is ignored while `cs_n` is high. Activity on it then changes neither `frame_data` nor `frame_valid`.
- R10: A `drdy_n` falling edge during a burst sets `overrun`. That edge starts no burst and produces no frame. `overrun` stays set until reset.
- R11: After reset `cs_n`=1, `sclk`=0, `mosi`=0, `frame_valid`=0, `overrun`=0 and `frame_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n | input | 1 | Converter ready line, active low, asynchronous |
| wide_sel | input | 1 | 1 selects 24-bit results, 0 selects 16-bit |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to converter |
| cs_n | output | 1 | Chip select, active low |
| frame_data | output | NUM_CH*W_WIDE | Channel words, channel i in slot i |
| frame_valid | output | 1 | One-cycle strobe for a new frame |
| overrun | output | 1 | Sticky flag: a ready edge was lost during a burst |

## Verification
The hardest condition to reach is a second ready edge that lands inside a running burst. The input has to rise and fall again while the sequencer is busy, and still allow for the synchronizer delay. The bench does this about twenty cycles into a narrow burst, long before the burst can end. It then counts frame strobes over a window longer than two bursts. A second hard case is a width change halfway through a burst. The bench flips `wide_sel` while the clock is running and checks the edge count and the frame layout of that burst.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;

    localparam int CH_COUNT    = 4;
    localparam int WORD_WIDE   = 24;
    localparam int WORD_NARROW = 16;
    localparam int CMD_BITS    = 8;
    localparam logic [1:0] DEV_ADDR_DEF = 2'b01;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_HIGH,
        SEQ_LOW,
        SEQ_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [1:0] dev_addr;
        logic [4:0] reg_addr;
        logic       rd;
    } ctrl_byte_t;

    function automatic logic [7:0] pack_ctrl(input logic [1:0] addr, input logic [4:0] start_reg);
        ctrl_byte_t c;
        c.dev_addr = addr;
        c.reg_addr = start_reg;
        c.rd       = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], drdy_n};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int HALF_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
    import adc_burst_pkg::*;
#(
    parameter int NUM_CH   = CH_COUNT,
    parameter int W_WIDE   = WORD_WIDE,
    parameter int W_NARROW = WORD_NARROW,
    parameter int CMD_W    = CMD_BITS,
    parameter logic [CMD_W-1:0] CTRL_BYTE = 8'h41
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    input  logic wide_sel,
    output logic run,
    output logic sclk,
    output logic mosi,
    output logic cs_n,
    output logic capture,
    output logic wide_q,
    output logic burst_done,
    output logic overrun
);
    localparam int LEN_N = CMD_W + NUM_CH * W_NARROW;
    localparam int LEN_W = CMD_W + NUM_CH * W_WIDE;
    localparam int CNT_W = $clog2(LEN_W + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] last_idx;
    logic [CMD_W-1:0] cmd_q;
    logic             sclk_q;
    logic             cs_q;
    logic             done_q;
    logic             ovr_q;
    logic             wide_r;

    assign last_idx = wide_r ? CNT_W'(LEN_W - 1) : CNT_W'(LEN_N - 1);
    assign run      = (state_q != SEQ_IDLE);
    assign capture  = tick && ((state_q == SEQ_LEAD) || (state_q == SEQ_LOW))
                      && (bit_q >= CNT_W'(CMD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            bit_q   <= '0;
            cmd_q   <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
            wide_r  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && (state_q != SEQ_IDLE)) begin
                ovr_q <= 1'b1;
            end
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_LEAD;
                        cs_q    <= 1'b0;
                        bit_q   <= '0;
                        cmd_q   <= CTRL_BYTE;
                        wide_r  <= wide_sel;
                    end
                end
                SEQ_LEAD, SEQ_LOW: begin
                    if (tick) begin
                        sclk_q  <= 1'b1;
                        state_q <= SEQ_HIGH;
                    end
                end
                SEQ_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        if (bit_q == last_idx) begin
                            state_q <= SEQ_TAIL;
                        end else begin
                            state_q <= SEQ_LOW;
                            bit_q   <= bit_q + 1'b1;
                            cmd_q   <= {cmd_q[CMD_W-2:0], 1'b0};
                        end
                    end
                end
                SEQ_TAIL: begin
                    if (tick) begin
                        cs_q    <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign sclk       = sclk_q;
    assign mosi       = cmd_q[CMD_W-1];
    assign cs_n       = cs_q;
    assign burst_done = done_q;
    assign overrun    = ovr_q;
    assign wide_q     = wide_r;
endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture #(
    parameter int NUM_CH   = 4,
    parameter int W_WIDE   = 24,
    parameter int W_NARROW = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       capture,
    input  logic                       miso,
    input  logic                       wide_q,
    input  logic                       burst_done,
    output logic [NUM_CH*W_WIDE-1:0]   frame_data,
    output logic                       frame_valid
);
    localparam int SH_W  = NUM_CH * W_WIDE;
    localparam int PAD_W = W_WIDE - W_NARROW;

    logic [SH_W-1:0] sh_q;
    logic [SH_W-1:0] assembled;
    logic [SH_W-1:0] frame_q;
    logic            valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (capture) begin
            sh_q <= {sh_q[SH_W-2:0], miso};
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        logic [W_WIDE-1:0] wide_word;
        logic [W_WIDE-1:0] narrow_word;
        assign wide_word   = sh_q[(NUM_CH-1-i)*W_WIDE +: W_WIDE];
        assign narrow_word = {{PAD_W{1'b0}}, sh_q[(NUM_CH-1-i)*W_NARROW +: W_NARROW]};
        assign assembled[i*W_WIDE +: W_WIDE] = wide_q ? wide_word : narrow_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= burst_done;
            if (burst_done) begin
                frame_q <= assembled;
            end
        end
    end

    assign frame_data  = frame_q;
    assign frame_valid = valid_q;
endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader
    import adc_burst_pkg::*;
#(
    parameter int         NUM_CH    = CH_COUNT,
    parameter int         W_WIDE    = WORD_WIDE,
    parameter int         W_NARROW  = WORD_NARROW,
    parameter int         HALF_DIV  = 12,
    parameter logic [1:0] DEV_ADDR  = DEV_ADDR_DEF,
    parameter logic [4:0] START_REG = 5'd0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     drdy_n,
    input  logic                     wide_sel,
    input  logic                     miso,
    output logic                     sclk,
    output logic                     mosi,
    output logic                     cs_n,
    output logic [NUM_CH*W_WIDE-1:0] frame_data,
    output logic                     frame_valid,
    output logic                     overrun
);
    localparam logic [CMD_BITS-1:0] CTRL_BYTE = pack_ctrl(DEV_ADDR, START_REG);

    logic start;
    logic run;
    logic tick;
    logic capture;
    logic wide_q;
    logic burst_done;

    adc_drdy_edge #(.SYNC_STAGES(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .drdy_n (drdy_n),
        .fall   (start)
    );

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    adc_burst_seq #(
        .NUM_CH    (NUM_CH),
        .W_WIDE    (W_WIDE),
        .W_NARROW  (W_NARROW),
        .CMD_W     (CMD_BITS),
        .CTRL_BYTE (CTRL_BYTE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tick       (tick),
        .wide_sel   (wide_sel),
        .run        (run),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .capture    (capture),
        .wide_q     (wide_q),
        .burst_done (burst_done),
        .overrun    (overrun)
    );

    adc_frame_capture #(
        .NUM_CH   (NUM_CH),
        .W_WIDE   (W_WIDE),
        .W_NARROW (W_NARROW)
    ) u_cap (
        .clk         (clk),
        .rst         (rst),
        .capture     (capture),
        .miso        (miso),
        .wide_q      (wide_q),
        .burst_done  (burst_done),
        .frame_data  (frame_data),
        .frame_valid (frame_valid)
    );
endmodule

// File: rtl/adc_burst_reader_chk.sv
module adc_burst_reader_chk #(
    parameter int FW = 96
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          sclk,
    input logic          mosi,
    input logic          frame_valid,
    input logic          overrun,
    input logic [FW-1:0] frame_data
);
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> (mosi == $past(mosi)));

    p_cs_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (!sclk && !$past(sclk)));

    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_valid_after_cs_r8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

    p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> $stable(frame_data));

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind adc_burst_reader adc_burst_reader_chk #(.FW(NUM_CH*W_WIDE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .frame_valid (frame_valid),
    .overrun     (overrun),
    .frame_data  (frame_data)
);

// File: tb/adc_burst_reader_test.sv
`timescale 1ns/1ps
module adc_burst_reader_test;
    localparam int HD = 3;
    localparam int FW = 96;
    localparam int NV = 6;

    // {wide, ch0, ch1, ch2, ch3}
    localparam logic [96:0] VEC [NV] = '{
        {1'b0, 24'h001234, 24'h00ABCD, 24'h000001, 24'h008000},
        {1'b1, 24'h123456, 24'hABCDEF, 24'h800001, 24'h7FFFFE},
        {1'b0, 24'h5AFFFF, 24'h5A0000, 24'h5AFFFF, 24'h5A0000},
        {1'b1, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF},
        {1'b1, 24'h000000, 24'h000000, 24'h000000, 24'h000000},
        {1'b0, 24'h00A5A5, 24'h005A5A, 24'h00C3C3, 24'h003C3C}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drdy_n = 1'b1;
    logic wide_sel = 1'b0;
    logic miso;
    logic sclk, mosi, cs_n, frame_valid, overrun;
    logic [FW-1:0] frame_data;

    always #5 clk = ~clk;

    adc_burst_reader #(.HALF_DIV(HD)) uut (
        .clk(clk), .rst(rst), .drdy_n(drdy_n), .wide_sel(wide_sel), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .frame_data(frame_data),
        .frame_valid(frame_valid), .overrun(overrun)
    );

    // converter model
    logic [23:0] mdl_word [4];
    logic        mdl_wide = 1'b0;
    logic        mdl_wlat = 1'b0;
    int          mdl_idx = 0;
    int          rise_cnt = 0;
    logic [7:0]  mosi_cap = 8'h00;
    logic        junk = 1'b0;
    time         t_rise = 0, t_fall = 0, t_csr = 0;
    int          half_cyc = 0, hold_cyc = 0;

    function automatic logic stream_bit(input int idx);
        int w, d, c, b;
        if (idx < 8) return 1'b1;
        w = mdl_wlat ? 24 : 16;
        d = idx - 8;
        c = d / w;
        b = d % w;
        if (c >= 4) return 1'b0;
        return mdl_word[c][w-1-b];
    endfunction

    always @(posedge clk) junk <= ~junk;
    always @(negedge cs_n) mdl_wlat <= mdl_wide;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) mdl_idx <= 0;
        else      mdl_idx <= mdl_idx + 1;
    end
    assign miso = cs_n ? junk : stream_bit(mdl_idx);

    always @(posedge sclk or negedge cs_n) begin
        if (sclk) begin
            rise_cnt <= rise_cnt + 1;
            if (rise_cnt < 8) mosi_cap <= {mosi_cap[6:0], mosi};
        end else begin
            rise_cnt <= 0;
            mosi_cap <= 8'h00;
        end
    end
    always @(posedge sclk) t_rise = $time;
    always @(negedge sclk) begin
        half_cyc = int'(($time - t_rise) / 10);
        t_fall   = $time;
    end
    always @(posedge cs_n) begin
        hold_cyc = int'(($time - t_fall) / 10);
        t_csr    = $time;
    end

    int tests = 0;
    int fails = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic trigger_checked();
        @(negedge clk);
        drdy_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 cs_n still high before sync delay", 32'(cs_n), 32'd1);
        @(negedge clk);
        check("R1 cs_n low on third edge", 32'(cs_n), 32'd0);
        repeat (3) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    task automatic wait_valid(output bit seen, output time tv);
        seen = 1'b0;
        tv = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (frame_valid) begin
                seen = 1'b1;
                tv = $time;
                break;
            end
        end
    endtask

    task automatic check_frame(input logic w, input logic [23:0] w0, w1, w2, w3, input string tag);
        logic [23:0] src [4];
        logic [23:0] exp;
        src[0] = w0; src[1] = w1; src[2] = w2; src[3] = w3;
        for (int i = 0; i < 4; i++) begin
            exp = w ? src[i] : {8'h00, src[i][15:0]};
            check($sformatf("R6 %s channel %0d", tag, i), 32'(frame_data[i*24 +: 24]), 32'(exp));
        end
    endtask

    initial begin
        #1_500_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit   seen;
        time  tv;
        logic [FW-1:0] snap;
        int   nvalid;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 cs_n", 32'(cs_n), 32'd1);
        check("R11 sclk", 32'(sclk), 32'd0);
        check("R11 mosi", 32'(mosi), 32'd0);
        check("R11 frame_valid", 32'(frame_valid), 32'd0);
        check("R11 overrun", 32'(overrun), 32'd0);
        check("R11 frame_data", 32'(frame_data[31:0] | frame_data[63:32] | frame_data[95:64]), 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic w;
            w = VEC[v][96];
            mdl_word[0] = VEC[v][95:72];
            mdl_word[1] = VEC[v][71:48];
            mdl_word[2] = VEC[v][47:24];
            mdl_word[3] = VEC[v][23:0];
            mdl_wide = w;
            wide_sel = w;
            trigger_checked();
            wait_valid(seen, tv);
            check($sformatf("R8 vector %0d frame strobe seen", v), 32'(seen), 32'd1);
            check($sformatf("R2 vector %0d control byte", v), 32'(mosi_cap), 32'h41);
            check($sformatf("R4 vector %0d clock count", v), 32'(rise_cnt), w ? 32'd104 : 32'd72);
            check($sformatf("R7 vector %0d half period", v), 32'(half_cyc), 32'(HD));
            check($sformatf("R7 vector %0d cs hold", v), 32'(hold_cyc), 32'(HD));
            check($sformatf("R8 vector %0d strobe delay ns", v), 32'(tv - t_csr), 32'd15);
            check_frame(w, mdl_word[0], mdl_word[1], mdl_word[2], mdl_word[3], $sformatf("vector %0d", v));
            @(negedge clk);
            check($sformatf("R8 vector %0d strobe one cycle", v), 32'(frame_valid), 32'd0);
            repeat (5) @(negedge clk);
        end

        // R5: width flip mid-burst
        mdl_word[0] = 24'h111111; mdl_word[1] = 24'h222222;
        mdl_word[2] = 24'h333333; mdl_word[3] = 24'h444444;
        mdl_wide = 1'b0;
        wide_sel = 1'b0;
        trigger_checked();
        repeat (40) @(negedge clk);
        wide_sel = 1'b1;
        wait_valid(seen, tv);
        check("R5 latched width clock count", 32'(rise_cnt), 32'd72);
        check_frame(1'b0, 24'h111111, 24'h222222, 24'h333333, 24'h444444, "R5 latched width");
        wide_sel = 1'b0;

        // R9: miso toggling while deselected
        snap = frame_data;
        nvalid = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (frame_valid) nvalid++;
        end
        check("R9 frame unchanged while deselected", 32'(frame_data == snap), 32'd1);
        check("R9 no strobe while deselected", 32'(nvalid), 32'd0);

        // R10: second ready edge during a burst
        check("R10 overrun clear before", 32'(overrun), 32'd0);
        @(negedge clk);
        drdy_n = 1'b0;
        repeat (5) @(negedge clk);
        drdy_n = 1'b1;
        repeat (20) @(negedge clk);
        drdy_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 overrun set", 32'(overrun), 32'd1);
        drdy_n = 1'b1;
        nvalid = 0;
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            if (frame_valid) nvalid++;
        end
        check("R10 only one frame", 32'(nvalid), 32'd1);
        check("R10 no extra burst", 32'(cs_n), 32'd1);
        trigger_checked();
        wait_valid(seen, tv);
        check("R10 overrun sticky after later burst", 32'(overrun), 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule